// File: doc/BRIEF.md
# Four-Bit Framed Sequence Detector

This block watches a single serial data line and cuts the accepted bits into back-to-back, non-overlapping frames of four. On the cycle that carries the fourth bit of a frame, the detection output rises for that one cycle if the frame equals either of two target words: 0-1-0-1 or 1-0-0-1, listed in arrival order. After each fourth bit the detector returns to its start-of-frame state, whatever the frame held. Runs of bits that span two frames are never matched.

A bit is taken only on a clock edge where the bit-valid strobe is high. When the strobe is low the frame position and the match tracking do not change. The output is Mealy type: it is formed in the same cycle from the registered frame state and the bit on the line. The two target words are parameters. They are written first-arrived bit leftmost, so the word `4'b0101` means 0, then 1, then 0, then 1.

A synchronous, active-high reset sends the detector back to the first bit of a frame. Resynchronising to the frame boundary after a slip is left to the surrounding logic.

Top module: `framed_seq_detector`

## Requirements
- R1: While `rst` is high, `z_out` is 0. After `rst` is released, the next accepted bit is the first bit of a new frame, even if the reset came in the middle of a frame.
- R2: `z_out` is 1 in the cycle that accepts the fourth bit of a frame whose bits, in arrival order, are 0,1,0,1.
- R3: `z_out` is 1 in the cycle that accepts the fourth bit of a frame whose bits, in arrival order, are 1,0,0,1.
- R4: `z_out` is 0 in every cycle that accepts the first, second or third bit of a frame.
- R5: For each of the other fourteen four-bit frames, `z_out` is 0 on the fourth bit.
- R6: In a cycle where `bit_valid` is 0, `z_out` is 0. The value of `x_in` in that cycle has no effect on frame position or on later detection.
- R7: Frames do not overlap. A target word that straddles a frame boundary is not detected, and a frame that ends in a match is followed by a fresh frame.
- R8: A frame whose leading bits already exclude both targets still takes exactly four accepted bits before the next frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to start of frame |
| bit_valid | input | 1 | High when `x_in` carries a bit to accept this cycle |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | One-cycle detection pulse on the fourth bit of a matching frame |

## Verification
Two events always fall in the same cycle: a detection and the forced return to the start of a frame, because both happen on the fourth accepted bit. The bench sends matching frames back to back with no idle cycle, and also sends a target word shifted across a frame boundary. The first case must give a pulse on every fourth bit. The second must give no pulse at all. Both outcomes show that the restart on the matching edge does not disturb the following frame. Reset asserted mid-frame, while the strobe is high, is the second same-cycle case. It is judged by the placement of the next pulse.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  // Bit expected at frame position pos; the first-arrived bit is the MSB.
  function automatic logic pattern_bit(input logic [31:0] pat,
                                       input int unsigned pos,
                                       input int unsigned len);
    logic [4:0] idx;
    idx = 5'(len - 1 - pos);
    return pat[idx];
  endfunction

  // Position of the last bit in a frame of length len.
  function automatic int unsigned last_pos(input int unsigned len);
    return len - 1;
  endfunction

endpackage

// File: rtl/fsd_frame_counter.sv
module fsd_frame_counter #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  output logic [POS_W-1:0] pos,
  output logic             at_last,
  output logic             at_first
);
  import fsd_pkg::*;

  localparam logic [POS_W-1:0] LAST = POS_W'(last_pos(FRAME_LEN));

  assign at_last  = (pos == LAST);
  assign at_first = (pos == '0);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (bit_valid)
      pos <= at_last ? '0 : pos + 1'b1;
  end

  // R7
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && at_last) |=> at_first);

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(pos));

endmodule

// File: rtl/fsd_pattern_tracker.sv
module fsd_pattern_tracker #(
  parameter int unsigned FRAME_LEN = 4,
  parameter logic [FRAME_LEN-1:0] PATTERN = '0,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             x_in,
  input  logic [POS_W-1:0] pos,
  input  logic             at_last,
  input  logic             at_first,
  output logic             hit
);
  import fsd_pkg::*;

  logic alive;
  logic expected;

  assign expected = pattern_bit(32'(PATTERN), 32'(pos), FRAME_LEN);
  assign hit      = alive && (x_in == expected);

  always_ff @(posedge clk) begin
    if (rst)
      alive <= 1'b1;
    else if (bit_valid)
      alive <= at_last ? 1'b1 : hit;
  end

  // R8
  fresh_frame_chk: assert property (@(posedge clk) disable iff (rst)
    at_first |-> alive);

endmodule

// File: rtl/framed_seq_detector.sv
module framed_seq_detector #(
  parameter int unsigned FRAME_LEN = 4,
  parameter int unsigned NUM_PAT   = 2,
  parameter logic [NUM_PAT*FRAME_LEN-1:0] PATTERNS = {4'b1001, 4'b0101}
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic x_in,
  output logic z_out
);
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

  logic [POS_W-1:0]   pos;
  logic               at_last;
  logic               at_first;
  logic [NUM_PAT-1:0] hits;
  logic               frame_end;

  fsd_frame_counter #(.FRAME_LEN(FRAME_LEN)) cnt_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid),
    .pos(pos), .at_last(at_last), .at_first(at_first)
  );

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_trk
    fsd_pattern_tracker #(
      .FRAME_LEN(FRAME_LEN),
      .PATTERN(PATTERNS[g*FRAME_LEN +: FRAME_LEN])
    ) trk_i (
      .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in),
      .pos(pos), .at_last(at_last), .at_first(at_first), .hit(hits[g])
    );
  end

  assign frame_end = !rst && bit_valid && at_last;
  assign z_out     = frame_end && (|hits);

  // R4
  z_only_last_chk: assert property (@(posedge clk) disable iff (rst)
    z_out |-> (bit_valid && at_last));

  // R7
  z_then_restart_chk: assert property (@(posedge clk) disable iff (rst)
    z_out |=> at_first);

  // R6
  z_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> !z_out);

endmodule

// File: tb/framed_seq_detector_tb.sv
module framed_seq_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic x_in = 1'b0;
  logic z_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  framed_seq_detector dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in), .z_out(z_out)
  );

  // Bench reference: collected bits of the current frame and their count.
  logic [3:0] held = '0;
  int         cnt  = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];
  event drv_ev;

  task automatic drive(input logic r, input logic v, input logic x, input string tag);
    item_t it;
    logic [3:0] frame;
    @(negedge clk);
    rst = r; bit_valid = v; x_in = x;
    frame = {held[2:0], x};
    it.tag = tag;
    if (r) begin
      it.exp = 1'b0;
      cnt = 0; held = '0;
    end else if (v) begin
      it.exp = (cnt == 3) && (frame == 4'b0101 || frame == 4'b1001);
      held = frame;
      cnt = (cnt == 3) ? 0 : cnt + 1;
    end else begin
      it.exp = 1'b0;
    end
    q.push_back(it);
    -> drv_ev;
  endtask

  task automatic send_frame(input logic [3:0] f, input string tag);
    for (int i = 3; i >= 0; i--) drive(1'b0, 1'b1, f[i], tag);
  endtask

  // Monitor: compare each expected item in the middle of the low phase.
  initial begin
    forever begin
      item_t it;
      @(drv_ev);
      #2;
      it = q.pop_front();
      checks++;
      if (z_out !== it.exp) begin
        fails++;
        $display("FAIL %s: z_out actual=%b expected=%b at %0t", it.tag, z_out, it.exp, $time);
      end
    end
  end

  initial begin
    // R1: reset with strobe high and data toggling
    drive(1'b1, 1'b1, 1'b1, "R1");
    drive(1'b1, 1'b1, 1'b0, "R1");
    drive(1'b1, 1'b1, 1'b1, "R1");
    // R2, R4
    send_frame(4'b0101, "R2");
    // R3, back to back with the previous match (R7)
    send_frame(4'b1001, "R3");
    send_frame(4'b0101, "R7");
    // R5: all sixteen frames
    for (int f = 0; f < 16; f++) send_frame(4'(f), "R5");
    // R8: early mismatch still consumes four bits
    send_frame(4'b1111, "R8");
    send_frame(4'b0101, "R8");
    send_frame(4'b0011, "R8");
    send_frame(4'b1001, "R8");
    // R6: idle cycles with noisy data inside a matching frame
    drive(1'b0, 1'b1, 1'b1, "R6");
    drive(1'b0, 1'b0, 1'b1, "R6");
    drive(1'b0, 1'b1, 1'b0, "R6");
    drive(1'b0, 1'b0, 1'b1, "R6");
    drive(1'b0, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b1, 1'b0, "R6");
    drive(1'b0, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b1, 1'b1, "R6");
    // R7: 0101 straddling a frame boundary: frames 1101, 0100
    send_frame(4'b1101, "R7");
    send_frame(4'b0100, "R7");
    // R7: 1001 straddling: frames 0010, 0100
    send_frame(4'b0010, "R7");
    send_frame(4'b0100, "R7");
    // R1: reset mid-frame, then a fresh frame must align
    drive(1'b0, 1'b1, 1'b0, "R1");
    drive(1'b0, 1'b1, 1'b1, "R1");
    drive(1'b1, 1'b1, 1'b0, "R1");
    send_frame(4'b1001, "R1");
    send_frame(4'b0101, "R1");
    drive(1'b0, 1'b0, 1'b0, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule